// File: doc/BRIEF.md
# Viterbi Add-Compare-Select Butterfly Array

This block advances the path metrics of a 16-state convolutional-code trellis by one step. It takes the 16 metrics of the previous step and eight branch metrics. Eight radix-2 butterflies then run side by side, and each one produces two new metrics and two survivor decisions. The incoming metrics are first sorted into an even-state half and an odd-state half. Each butterfly pairs one even-state metric with the odd-state metric next to it.

Larger metrics are better, and all sums saturate at the signed 16-bit limits. A step is taken whenever the input valid strobe is high. Results are registered and appear one clock later, together with an output valid. Branch metric generation, metric normalization and traceback are handled by neighbouring blocks.

Top module: `acs_butterfly16`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `pm_out`, `dec_out` and `out_vld` to zero, whatever the other inputs do.
- R2: When `in_vld` is high at a rising edge, the results for that step appear after that edge, and `out_vld` is high for exactly one cycle per accepted step.
- R3: While `in_vld` is low, changes on `pm_in` and `bm_in` have no effect: `pm_out` and `dec_out` keep their last values.
- R4: Old state i occupies `pm_in[16*i+15:16*i]`. Butterfly j takes state 2j as its even metric A and state 2j+1 as its odd metric B.
- R5: Butterfly j takes its branch metric M from `bm_in[16*j+15:16*j]`. New state j is max(A+M, B-M), and new state j+8 is max(A-M, B+M). New state i is found in `pm_out[16*i+15:16*i]`.
- R6: Every addition and subtraction is signed and saturates at +32767 and -32768 instead of wrapping. The comparison is made on the saturated values.
- R7: Bit i of `dec_out` is 1 when the first candidate of new state i (A+M, or A-M for states 8 to 15) is greater than or equal to the second candidate. On a tie the bit is 1 and the first candidate is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Step strobe: accept `pm_in` and `bm_in` at this edge |
| pm_in | input | 256 | Previous-step path metrics, 16 signed 16-bit values, state i at bits 16i+15:16i |
| bm_in | input | 128 | Branch metrics, 8 signed 16-bit values, butterfly j at bits 16j+15:16j |
| out_vld | output | 1 | High for the cycle in which a new step result is presented |
| pm_out | output | 256 | Updated path metrics, new state i at bits 16i+15:16i |
| dec_out | output | 16 | Survivor decisions, bit i for new state i |

## Verification
Each result is registered once. The metrics, decisions and valid flag for a step strobed at one rising edge are all due right after that edge. The bench drives its inputs at the falling edge, lets one rising edge pass, and compares at the following falling edge. In the cycles after a step the strobe is held low while the inputs are changed. At each of those cycles the bench checks that the outputs still hold the previous results and that the valid flag stays low. Reset is checked the same way: one edge after it is applied, while the strobe is high.

// File: rtl/acs_butterfly16.sv
module acs_butterfly16 #(
  parameter int MW  = 16,
  parameter int NBF = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_vld,
  input  logic [2*NBF*MW-1:0]   pm_in,
  input  logic [NBF*MW-1:0]     bm_in,
  output logic                  out_vld,
  output logic [2*NBF*MW-1:0]   pm_out,
  output logic [2*NBF-1:0]      dec_out
);
  localparam int NS = 2 * NBF;
  localparam int EW = MW + 1;
  localparam logic signed [MW-1:0] SMAX = {1'b0, {(MW-1){1'b1}}};
  localparam logic signed [MW-1:0] SMIN = {1'b1, {(MW-1){1'b0}}};

  function automatic logic signed [MW-1:0] sat(input logic [EW-1:0] v);
    if (v[EW-1] != v[EW-2]) return v[EW-1] ? SMIN : SMAX;
    return v[MW-1:0];
  endfunction

  logic signed [MW-1:0] cand_f [NS];
  logic signed [MW-1:0] cand_s [NS];
  logic signed [MW-1:0] nxt_pm [NS];
  logic                 nxt_dec [NS];

  for (genvar j = 0; j < NBF; j++) begin : g_bfly
    logic signed [MW-1:0] ev, od, bm;
    assign ev = pm_in[2*j*MW +: MW];
    assign od = pm_in[(2*j+1)*MW +: MW];
    assign bm = bm_in[j*MW +: MW];

    assign cand_f[j]     = sat({ev[MW-1], ev} + {bm[MW-1], bm});
    assign cand_s[j]     = sat({od[MW-1], od} - {bm[MW-1], bm});
    assign cand_f[j+NBF] = sat({ev[MW-1], ev} - {bm[MW-1], bm});
    assign cand_s[j+NBF] = sat({od[MW-1], od} + {bm[MW-1], bm});

    AST_NO_WRAP_ADD: assert property (@(posedge clk) disable iff (rst)
      (in_vld && ev >= 0 && bm >= 0) |-> (cand_f[j] >= ev)); // R6
    AST_NO_WRAP_SUB: assert property (@(posedge clk) disable iff (rst)
      (in_vld && ev < 0 && bm >= 0) |-> (cand_f[j+NBF] <= ev)); // R6
  end

  for (genvar i = 0; i < NS; i++) begin : g_sel
    assign nxt_dec[i] = (cand_f[i] >= cand_s[i]);
    assign nxt_pm[i]  = nxt_dec[i] ? cand_f[i] : cand_s[i];

    AST_PICK_MAX: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> ($signed(pm_out[i*MW +: MW]) >= $past(cand_f[i]) &&
                  $signed(pm_out[i*MW +: MW]) >= $past(cand_s[i]))); // R5
    AST_DEC_SEL: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> (dec_out[i] ? ($signed(pm_out[i*MW +: MW]) == $past(cand_f[i]))
                             : ($signed(pm_out[i*MW +: MW]) == $past(cand_s[i]) &&
                                $past(cand_s[i]) > $past(cand_f[i])))); // R7
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      pm_out  <= '0;
      dec_out <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        for (int i = 0; i < NS; i++) begin
          pm_out[i*MW +: MW] <= nxt_pm[i];
          dec_out[i]         <= nxt_dec[i];
        end
      end
    end
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld); // R2
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(pm_out) && $stable(dec_out))); // R3
endmodule

// File: tb/acs_butterfly16_test.sv
module acs_butterfly16_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic [255:0] pm_in = '0;
  logic [127:0] bm_in = '0;
  logic         out_vld;
  logic [255:0] pm_out;
  logic [15:0]  dec_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  acs_butterfly16 uut (.clk(clk), .rst(rst), .in_vld(in_vld), .pm_in(pm_in),
    .bm_in(bm_in), .out_vld(out_vld), .pm_out(pm_out), .dec_out(dec_out));

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic void model(input logic [255:0] p, input logic [127:0] b,
                                output logic [255:0] ep, output logic [15:0] ed);
    ep = '0; ed = '0;
    for (int j = 0; j < 8; j++) begin
      int a, o, m, f1, s1, f2, s2;
      a = int'($signed(p[32*j +: 16]));
      o = int'($signed(p[32*j+16 +: 16]));
      m = int'($signed(b[16*j +: 16]));
      f1 = sat16(a + m); s1 = sat16(o - m);
      f2 = sat16(a - m); s2 = sat16(o + m);
      ed[j]   = (f1 >= s1);
      ed[j+8] = (f2 >= s2);
      ep[16*j +: 16]     = 16'(ed[j] ? f1 : s1);
      ep[16*(j+8) +: 16] = 16'(ed[j+8] ? f2 : s2);
    end
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic [255:0] p, input logic [127:0] b);
    logic [255:0] ep; logic [15:0] ed;
    model(p, b, ep, ed);
    @(negedge clk);
    pm_in = p; bm_in = b; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    pm_in = {8{$urandom()}}; bm_in = {4{$urandom()}};
    chk({req, " R2 out_vld"}, 256'(out_vld), 256'(1));
    chk({req, " R5 metrics"}, pm_out, ep);
    chk({req, " R7 decisions"}, 256'(dec_out), 256'(ed));
  endtask

  task automatic idle_check(input int n);
    logic [255:0] hp; logic [15:0] hd;
    hp = pm_out; hd = dec_out;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pm_in = {8{$urandom()}}; bm_in = {4{$urandom()}};
      chk("R3 hold metrics", pm_out, hp);
      chk("R3 hold decisions", 256'(dec_out), 256'(hd));
      chk("R2 no valid when idle", 256'(out_vld), 256'(0));
    end
  endtask

  function automatic logic [255:0] fill_pm(input logic [15:0] v);
    return {16{v}};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [255:0] p; logic [127:0] b;
    void'($urandom(32'h5eed_0042));
    in_vld = 1'b1; pm_in = {8{32'hdead_beef}}; bm_in = {4{32'h1234_5678}};
    repeat (2) @(negedge clk);
    chk("R1 reset metrics", pm_out, '0);
    chk("R1 reset decisions", 256'(dec_out), '0);
    chk("R1 reset valid", 256'(out_vld), '0);
    in_vld = 1'b0;
    rst = 1'b0;

    step("tie zeros R7", '0, '0);
    step("tie equal", fill_pm(16'd100), '0);

    for (int i = 0; i < 16; i++) p[16*i +: 16] = 16'(i * 37 - 200 + (i % 2) * 500);
    step("R4 regroup odd larger", p, '0);
    for (int i = 0; i < 16; i++) p[16*i +: 16] = 16'(1000 - i * 3 - (i % 2) * 700);
    step("R4 regroup even larger", p, '0);
    for (int j = 0; j < 8; j++) b[16*j +: 16] = 16'(j * 11 + 1);
    step("R5 per-butterfly bm", '0, b);

    step("R6 positive sat", fill_pm(16'h7fff), {8{16'h7fff}});
    step("R6 negative sat", fill_pm(16'h8000), {8{16'h7fff}});
    step("R6 bm min", fill_pm(16'h4000), {8{16'h8000}});
    step("R6 mixed", {8{16'h8000, 16'h7fff}}, {8{16'h8000}});
    idle_check(4);

    for (int t = 0; t < 300; t++) begin
      for (int i = 0; i < 8; i++) p[32*i +: 32] = $urandom();
      for (int i = 0; i < 4; i++) b[32*i +: 32] = $urandom();
      if (t % 3 == 0) b = b >>> 4;
      step("random", p, b);
      if (t % 50 == 7) idle_check(2);
    end

    @(negedge clk);
    rst = 1'b1; in_vld = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset metrics", pm_out, '0);
    chk("R1 mid-run reset valid", 256'(out_vld), '0);
    rst = 1'b0; in_vld = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule